// File: doc/BRIEF.md
# Register Access Wrap Sequencer

This block sits between a simple register-access requester and the internal register bus of a target whose low-offset registers can lock up unless each access is bracketed by harmless reads. The requester issues one access at a time: a read, a write, or a bit-set or bit-clear read-modify-write. The block runs each access as a short, fixed series of bus transactions. The series depends on the target offset and on a flag that says whether the attached target has the fault.

For an affected target and an offset below 0x45000, the real access is preceded by one guard read. The guard read's address is picked from the target offset. The real access is followed by one or two trailing guard reads. Guard reads are always reads, their data is dropped, and only the real access's read data goes back to the requester. Offsets at or above 0x45000, and every access when the fault flag is clear, go to the bus as the bare access. A read-modify-write is run as a read pass followed by a write pass of the merged value, and each pass gets its own guard reads.

Top module: `mmr_wrap_seq`

## Requirements
- R1: After reset, req_ready is 1, and bus_valid and rsp_valid are 0.
- R2: When req_rev_hit is 0, each pass puts exactly one transaction on the bus: the requested access at the requested offset.
- R3: When req_rev_hit is 1 and the offset is 0x45000 or above, only the requested access goes to the bus. An offset of 0x44FF8 is still wrapped.
- R4: A wrapped pass starts with a guard read. Its address is 0xC0 for offsets 0x0 and 0x80, 0x28 for offsets 0x148 and 0x200, and 0x158 for every other wrapped offset.
- R5: After the real access of a wrapped pass, a guard read to 0x38 is issued if and only if the offset is 0x100. It comes before the final guard read.
- R6: Every wrapped pass ends with a guard read to 0xB050.
- R7: Guard reads have bus_write 0 and bus_wdata 0, even when the real access is a write. Real reads also drive bus_wdata 0.
- R8: rsp_data returns the bus response data of the real read. Guard read data is discarded. A plain write returns 0.
- R9: A request is accepted only when req_ready is 1, which holds only while the block is idle. Bus transactions are issued one at a time, each waits for its bus_rsp_valid, and bus_valid, bus_addr, bus_write and bus_wdata hold steady while bus_ready is 0.
- R10: req_op encodes 0 read, 1 write, 2 set bits, 3 clear bits. For set and clear, the read pass is followed by a write of old|req_wdata (set) or old&~req_wdata (clear) to the same offset. rsp_data returns the old value.
- R11: rsp_valid and rsp_data hold until rsp_ready is sampled 1. The block is then idle on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle, request accepted this cycle |
| req_op | input | 2 | 0 read, 1 write, 2 set bits, 3 clear bits |
| req_addr | input | AW | Register offset (8-byte aligned) |
| req_wdata | input | DW | Write data or bit mask |
| req_rev_hit | input | 1 | Target has the fault; enables wrapping |
| rsp_valid | output | 1 | Response available |
| rsp_ready | input | 1 | Requester takes the response |
| rsp_data | output | DW | Real read data (0 for writes) |
| bus_valid | output | 1 | Bus transaction request |
| bus_ready | input | 1 | Bus accepts the transaction |
| bus_write | output | 1 | 1 write, 0 read |
| bus_addr | output | AW | Bus offset |
| bus_wdata | output | DW | Bus write data |
| bus_rsp_valid | input | 1 | Bus completion for the outstanding transaction |
| bus_rsp_data | input | DW | Bus read data |

## Verification
A wrong step or pass state inside the block shows up within one bus transaction as a missing, extra or misaddressed entry in the logged bus stream. A bad capture of the real read shows up as wrong rsp_data when the response is returned. The bench sweeps every operation across every special offset, the wrap-limit edges and both fault-flag values, with bus stalls in the stream. It compares the full ordered transaction list and the returned data against arithmetic predictions, so a misordered or dropped guard read is caught at the request that caused it.

// File: rtl/mmr_wrap_pkg.sv
package mmr_wrap_pkg;

    typedef enum logic [1:0] {
        OP_RD  = 2'd0,
        OP_WR  = 2'd1,
        OP_SET = 2'd2,
        OP_CLR = 2'd3
    } acc_op_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ISSUE = 2'd1,
        ST_WAIT  = 2'd2,
        ST_RESP  = 2'd3
    } seq_st_e;

    typedef enum logic [1:0] {
        STEP_PRE    = 2'd0,
        STEP_REAL   = 2'd1,
        STEP_POST_A = 2'd2,
        STEP_POST_B = 2'd3
    } seq_step_e;

    // Recipe constants (32-bit, narrowed at use)
    localparam logic [31:0] WRAP_LIMIT_C = 32'h0004_5000;
    localparam logic [31:0] GUARD_TAIL_C = 32'h0000_B050;
    localparam logic [31:0] GUARD_MID_C  = 32'h0000_0038;
    localparam logic [31:0] MID_TRIG_C   = 32'h0000_0100;
    localparam logic [31:0] PRE_DFLT_C   = 32'h0000_0158;

    // Offset-to-guard match table
    localparam int N_MATCH = 4;
    localparam logic [31:0] MATCH_OFF [N_MATCH] = '{32'h0, 32'h80, 32'h148, 32'h200};
    localparam logic [31:0] MATCH_PRE [N_MATCH] = '{32'hC0, 32'hC0, 32'h28, 32'h28};

endpackage

// File: rtl/mmr_wrap_classify.sv
module mmr_wrap_classify
    import mmr_wrap_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic [AW-1:0] offset,
    input  logic          rev_hit,
    output logic          wrap,
    output logic [AW-1:0] pre_addr,
    output logic          need_mid
);
    localparam logic [AW-1:0] LIMIT = AW'(WRAP_LIMIT_C);

    logic [N_MATCH-1:0] hit_vec;

    for (genvar g = 0; g < N_MATCH; g++) begin : g_match
        assign hit_vec[g] = (offset == AW'(MATCH_OFF[g]));
    end

    always_comb begin
        pre_addr = AW'(PRE_DFLT_C);
        for (int i = N_MATCH - 1; i >= 0; i--) begin
            if (hit_vec[i]) pre_addr = AW'(MATCH_PRE[i]);
        end
    end

    assign wrap     = rev_hit && (offset < LIMIT);
    assign need_mid = (offset == AW'(MID_TRIG_C));

endmodule

// File: rtl/mmr_wrap_merge.sv
module mmr_wrap_merge
    import mmr_wrap_pkg::*;
#(
    parameter int DW = 64
) (
    input  acc_op_e       op,
    input  logic [DW-1:0] old_val,
    input  logic [DW-1:0] mask,
    output logic [DW-1:0] merged
);
    always_comb begin
        case (op)
            OP_SET:  merged = old_val | mask;
            OP_CLR:  merged = old_val & ~mask;
            default: merged = mask;
        endcase
    end
endmodule

// File: rtl/mmr_wrap_seq.sv
module mmr_wrap_seq
    import mmr_wrap_pkg::*;
#(
    parameter int AW = 32,
    parameter int DW = 64
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    output logic          req_ready,
    input  logic [1:0]    req_op,
    input  logic [AW-1:0] req_addr,
    input  logic [DW-1:0] req_wdata,
    input  logic          req_rev_hit,
    output logic          rsp_valid,
    input  logic          rsp_ready,
    output logic [DW-1:0] rsp_data,
    output logic          bus_valid,
    input  logic          bus_ready,
    output logic          bus_write,
    output logic [AW-1:0] bus_addr,
    output logic [DW-1:0] bus_wdata,
    input  logic          bus_rsp_valid,
    input  logic [DW-1:0] bus_rsp_data
);
    localparam logic [AW-1:0] MID_ADDR  = AW'(GUARD_MID_C);
    localparam logic [AW-1:0] TAIL_ADDR = AW'(GUARD_TAIL_C);

    typedef struct packed {
        seq_st_e       st;
        seq_step_e     step;
        logic          pass2;
        acc_op_e       op;
        logic [AW-1:0] addr;
        logic [DW-1:0] wdata;
        logic          wrap;
        logic [AW-1:0] pre_addr;
        logic          need_mid;
        logic [DW-1:0] rdata;
    } seq_state_t;

    seq_state_t q, d;

    logic          cls_wrap;
    logic [AW-1:0] cls_pre;
    logic          cls_mid;
    logic [DW-1:0] merged;
    logic          pass_end;
    logic          is_rmw;

    mmr_wrap_classify #(.AW(AW)) u_classify (
        .offset   (req_addr),
        .rev_hit  (req_rev_hit),
        .wrap     (cls_wrap),
        .pre_addr (cls_pre),
        .need_mid (cls_mid)
    );

    mmr_wrap_merge #(.DW(DW)) u_merge (
        .op      (q.op),
        .old_val (q.rdata),
        .mask    (q.wdata),
        .merged  (merged)
    );

    assign is_rmw = (q.op == OP_SET) || (q.op == OP_CLR);

    always_comb begin
        d        = q;
        pass_end = 1'b0;
        case (q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    d.st       = ST_ISSUE;
                    d.op       = acc_op_e'(req_op);
                    d.addr     = req_addr;
                    d.wdata    = req_wdata;
                    d.wrap     = cls_wrap;
                    d.pre_addr = cls_pre;
                    d.need_mid = cls_mid;
                    d.pass2    = 1'b0;
                    d.rdata    = '0;
                    d.step     = cls_wrap ? STEP_PRE : STEP_REAL;
                end
            end
            ST_ISSUE: begin
                if (bus_ready) d.st = ST_WAIT;
            end
            ST_WAIT: begin
                if (bus_rsp_valid) begin
                    d.st = ST_ISSUE;
                    case (q.step)
                        STEP_PRE: d.step = STEP_REAL;
                        STEP_REAL: begin
                            if (!q.pass2 && q.op != OP_WR) d.rdata = bus_rsp_data;
                            if (q.wrap) d.step = q.need_mid ? STEP_POST_A : STEP_POST_B;
                            else        pass_end = 1'b1;
                        end
                        STEP_POST_A: d.step = STEP_POST_B;
                        default:     pass_end = 1'b1;
                    endcase
                    if (pass_end) begin
                        if (is_rmw && !q.pass2) begin
                            d.pass2 = 1'b1;
                            d.step  = q.wrap ? STEP_PRE : STEP_REAL;
                        end else begin
                            d.st = ST_RESP;
                        end
                    end
                end
            end
            default: begin
                if (rsp_ready) d.st = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    // Bus side
    always_comb begin
        case (q.step)
            STEP_PRE:    bus_addr = q.pre_addr;
            STEP_REAL:   bus_addr = q.addr;
            STEP_POST_A: bus_addr = MID_ADDR;
            default:     bus_addr = TAIL_ADDR;
        endcase
    end

    assign bus_valid = (q.st == ST_ISSUE);
    assign bus_write = (q.step == STEP_REAL) && ((q.op == OP_WR) || q.pass2);
    assign bus_wdata = !bus_write ? '0 : (q.pass2 ? merged : q.wdata);

    // Requester side
    assign req_ready = (q.st == ST_IDLE);
    assign rsp_valid = (q.st == ST_RESP);
    assign rsp_data  = rsp_valid ? q.rdata : '0;

    // Checks
    p_stall_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        bus_valid && !bus_ready |=> bus_valid && $stable(bus_addr)
                                    && $stable(bus_write) && $stable(bus_wdata));

    p_busy_no_accept_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid || rsp_valid) |-> !req_ready);

    p_rsp_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_data));

    p_guard_is_read_r7: assert property (@(posedge clk) disable iff (!rst_n)
        bus_valid && (bus_addr != q.addr) |-> !bus_write && (bus_wdata == '0));

    p_bypass_addr_r2: assert property (@(posedge clk) disable iff (!rst_n)
        bus_valid && !q.wrap |-> bus_addr == q.addr);

    p_release_r11: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && rsp_ready |=> req_ready);

endmodule

// File: tb/mmr_wrap_seq_tb.sv
`timescale 1ns/1ps
module mmr_wrap_seq_tb;
    localparam int AW = 32;
    localparam int DW = 64;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_ready;
    logic [1:0]    req_op = 2'd0;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_wdata = '0;
    logic          req_rev_hit = 1'b0;
    logic          rsp_valid;
    logic          rsp_ready = 1'b0;
    logic [DW-1:0] rsp_data;
    logic          bus_valid;
    logic          bus_ready = 1'b1;
    logic          bus_write;
    logic [AW-1:0] bus_addr;
    logic [DW-1:0] bus_wdata;
    logic          bus_rsp_valid = 1'b0;
    logic [DW-1:0] bus_rsp_data = '0;

    int n_checks = 0;
    int n_fail   = 0;
    int cyc      = 0;

    always #4 clk = ~clk;

    mmr_wrap_seq #(.AW(AW), .DW(DW)) u_dut (.*);

    function automatic logic [DW-1:0] tgt_data(logic [AW-1:0] a);
        return {a ^ 32'h5A5A_0F0F, ~a};
    endfunction

    // Target model: one-cycle completion
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (bus_valid && bus_ready) begin
            bus_rsp_valid <= 1'b1;
            bus_rsp_data  <= bus_write ? 64'h0 : tgt_data(bus_addr);
        end else begin
            bus_rsp_valid <= 1'b0;
            bus_rsp_data  <= '0;
        end
    end

    always @(negedge clk) bus_ready <= (cyc % 3) != 0;

    // Logged bus stream
    logic          log_w [$];
    logic [AW-1:0] log_a [$];
    logic [DW-1:0] log_d [$];
    logic          exp_w [$];
    logic [AW-1:0] exp_a [$];
    logic [DW-1:0] exp_d [$];
    string         exp_t [$];

    logic          prev_stall = 1'b0;
    logic [AW-1:0] prev_addr  = '0;
    logic [DW-1:0] prev_wd    = '0;

    task automatic check(input bit ok, input string tag,
                         input logic [DW-1:0] act, input logic [DW-1:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    always @(posedge clk) begin
        if (rst_n) begin
            if (prev_stall)
                check(bus_valid && bus_addr == prev_addr && bus_wdata == prev_wd,
                      "R9 stall hold", {32'h0, bus_addr}, {32'h0, prev_addr});
            prev_stall = bus_valid && !bus_ready;
            prev_addr  = bus_addr;
            prev_wd    = bus_wdata;
            if (bus_valid && bus_ready) begin
                log_w.push_back(bus_write);
                log_a.push_back(bus_addr);
                log_d.push_back(bus_wdata);
            end
        end
    end

    task automatic push_exp(input logic w, input logic [AW-1:0] a,
                            input logic [DW-1:0] dat, input string t);
        exp_w.push_back(w); exp_a.push_back(a); exp_d.push_back(dat); exp_t.push_back(t);
    endtask

    function automatic logic [AW-1:0] pre_of(logic [AW-1:0] a);
        if (a == 32'h0 || a == 32'h80)         return 32'hC0;
        else if (a == 32'h148 || a == 32'h200) return 32'h28;
        else                                   return 32'h158;
    endfunction

    task automatic build_exp(input bit rev, input logic [1:0] op,
                             input logic [AW-1:0] a, input logic [DW-1:0] wd);
        bit wrapped = rev && (a < 32'h45000);
        int passes  = (op >= 2) ? 2 : 1;
        logic [DW-1:0] old = tgt_data(a);
        logic [DW-1:0] mrg = (op == 2) ? (old | wd) : (old & ~wd);
        for (int p = 0; p < passes; p++) begin
            if (wrapped) push_exp(1'b0, pre_of(a), '0, "R4 guard before");
            if (p == 1)
                push_exp(1'b1, a, mrg, "R10 merged write");
            else if (op == 1)
                push_exp(1'b1, a, wd, wrapped ? "R7 real write" : (rev ? "R3 bare" : "R2 bare"));
            else
                push_exp(1'b0, a, '0, wrapped ? "R8 real read" : (rev ? "R3 bare" : "R2 bare"));
            if (wrapped && a == 32'h100) push_exp(1'b0, 32'h38, '0, "R5 mid guard");
            if (wrapped) push_exp(1'b0, 32'hB050, '0, "R6 tail guard");
        end
    endtask

    task automatic run_one(input bit rev, input logic [1:0] op, input logic [AW-1:0] a);
        logic [DW-1:0] wd = {a, 32'hF0F0_1234} ^ {62'h0, op};
        logic [DW-1:0] got;
        bit busy_ok = 1'b1;
        int guard = 0;
        log_w.delete(); log_a.delete(); log_d.delete();
        exp_w.delete(); exp_a.delete(); exp_d.delete(); exp_t.delete();
        build_exp(rev, op, a, wd);

        @(negedge clk);
        req_valid = 1'b1; req_op = op; req_addr = a; req_wdata = wd; req_rev_hit = rev;
        @(negedge clk);
        req_valid = 1'b1; req_addr = 32'h200;   // second request must be held off
        while (!rsp_valid && guard < 1000) begin
            if (req_ready) busy_ok = 1'b0;
            @(negedge clk);
            guard++;
        end
        req_valid = 1'b0;
        check(busy_ok, "R9 busy req_ready", {63'h0, busy_ok}, 64'h1);
        got = rsp_data;
        check(got == ((op == 1) ? 64'h0 : tgt_data(a)),
              (op >= 2) ? "R10 old value" : "R8 rsp data", got,
              (op == 1) ? 64'h0 : tgt_data(a));
        @(negedge clk);
        @(negedge clk);
        check(rsp_valid && rsp_data == got, "R11 rsp hold", rsp_data, got);
        rsp_ready = 1'b1;
        @(negedge clk);
        rsp_ready = 1'b0;
        check(!rsp_valid && req_ready, "R11 release", {62'h0, rsp_valid, req_ready}, 64'h1);

        check(log_a.size() == exp_a.size(),
              !rev ? "R2 count" : (a >= 32'h45000 ? "R3 count" : "R6 count"),
              64'(log_a.size()), 64'(exp_a.size()));
        for (int i = 0; i < exp_a.size() && i < log_a.size(); i++) begin
            check(log_w[i] == exp_w[i] && log_a[i] == exp_a[i] && log_d[i] == exp_d[i],
                  exp_t[i], {log_w[i], 31'h0, log_a[i]} ^ log_d[i],
                  {exp_w[i], 31'h0, exp_a[i]} ^ exp_d[i]);
            if (!exp_w[i] && exp_a[i] != a)
                check(!log_w[i] && log_d[i] == '0, "R7 guard is read",
                      {63'h0, log_w[i]} | log_d[i], 64'h0);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        check(1'b0, "watchdog", 64'h0, 64'h1);
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        logic [AW-1:0] offs [11] = '{32'h0, 32'h80, 32'h148, 32'h200, 32'h100, 32'h8,
                                     32'h38, 32'h44FF8, 32'h45000, 32'h50000, 32'h7FFFFF8};
        repeat (3) @(negedge clk);
        check(req_ready && !bus_valid && !rsp_valid, "R1 reset state",
              {61'h0, req_ready, bus_valid, rsp_valid}, 64'h4);
        rst_n = 1'b1;
        @(negedge clk);
        check(req_ready && !bus_valid && !rsp_valid, "R1 after reset",
              {61'h0, req_ready, bus_valid, rsp_valid}, 64'h4);
        for (int r = 0; r < 2; r++)
            for (int o = 0; o < 4; o++)
                for (int k = 0; k < 11; k++)
                    run_one(r[0], o[1:0], offs[k]);
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule